// File: doc/BRIEF.md
# Byte-Addressable Bus Memory with Random Stalls

This block is a subordinate on an AHB-Lite bus that holds a small RAM mapped into a fixed address window. It latches the control signals of each transfer in the address phase and then completes the transfer in the data phase that follows. Writes change only the bytes picked out by the transfer size and the low address bits. Reads place the stored bytes on their own lanes of the read bus and drive every other bit to zero.

A 16-bit LFSR stretches data phases by a varying number of wait states. The purpose is to exercise the stall handling of whatever drives the bus. Idle and busy slots never stall. If the bus reports ready while this block is holding its data phase low, the block records the protocol error in a flag that stays set until reset. The block never signals an error response.

The window start, the memory size, the bus widths, the LFSR seed and the wait enable are all parameters. The window start must be aligned to the bus width in bytes.

Top module: `ahbmem_sub`

## Requirements
- R1: After a synchronous active-low reset, `readyout_o` is 1, `proto_err_o` is 0 and `rdata_o` is zero. The memory contents are left undefined.
- R2: A transfer is taken when `sel_i` and `ready_i` are both high at a rising edge and `trans_i` is 2 (first beat) or 3 (following beat). A `trans_i` of 0 (idle) or 1 (busy) writes nothing, gives `readyout_o` = 1 and gives `rdata_o` = 0 in the next cycle.
- R3: Only addresses from `BASE` to `BASE+MEM_BYTES-1` reach memory. A transfer outside that range is handled like an unselected slot: it does not alias into the RAM, and a read returns zero.
- R4: The first lane is the address modulo the bus width in bytes. `size_i` = 0, 1 and 2 cover 1, 2 and 4 bytes starting at that lane. On a write, each covered byte is taken from the same lane of `wdata_i`, and bytes outside the covered lanes keep their contents.
- R5: During the data phase of a read, `rdata_o` carries the stored bytes on the covered lanes and zero on all other bits. At all other times `rdata_o` is zero.
- R6: `resp_o` is always 0.
- R7: When `WAITS_EN` is 1, each data phase of a taken transfer holds `readyout_o` low for a number of cycles given by an LFSR. The number varies from one transfer to the next, and the control of the taken transfer is held while stalled.
- R8: `proto_err_o` is set when `ready_i` is sampled high while `readyout_o` is low. It is cleared only by reset.
- R9: Write data is sampled only on the edge that ends the data phase. Values on `wdata_i` during wait cycles have no effect.
- R10: A new address phase may be presented during a data phase. It is taken on the edge that completes that data phase, and a read that directly follows a write to the same word returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Subordinate select |
| ready_i | input | 1 | Bus-wide ready, marks the end of the current data phase |
| trans_i | input | 2 | Transfer type: 0 idle, 1 busy, 2 first beat, 3 following beat |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | log2 of the transfer size in bytes |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data, valid in the data phase |
| readyout_o | output | 1 | This block's ready; low inserts a wait state |
| resp_o | output | 1 | Response, always OKAY (0) |
| rdata_o | output | DATA_W | Read data on the covered lanes, zero elsewhere |
| proto_err_o | output | 1 | Sticky flag: bus ready seen while this block stalled |

## Verification
The bench attacks lane placement with byte and halfword writes into words that already hold data. A design with a wrong mask would overwrite a neighbour byte or return data on the wrong lanes. Writes just past the end and just before the start of the window are followed by a read of the first word, which catches a design that wraps the word index and aliases into the RAM. During every wait cycle the bench drives inverted write data, so a design that samples write data before the final edge stores garbage. It also sends a back-to-back write then read to one word, and forces a bus ready during a stall: the first finds stale read data, and the second finds an error flag that is missing or does not stick.

// File: rtl/ahbmem_pkg.sv
// Shared types for the bus memory: transfer encodings and the registered
// data-phase control. Assumes the two-bit transfer type of AHB-Lite.
package ahbmem_pkg;

    typedef enum logic [1:0] {
        XFER_IDLE   = 2'd0,
        XFER_BUSY   = 2'd1,
        XFER_NONSEQ = 2'd2,
        XFER_SEQ    = 2'd3
    } xfer_t;

    typedef struct packed {
        logic       valid;
        logic       write;
        logic [2:0] size;
    } dctl_t;

endpackage

// File: rtl/ahbmem_wait_gen.sv
// Wait-state source: a 16-bit Fibonacci LFSR (x^16+x^14+x^13+x^11+1) whose
// low bit says whether a pending data phase may finish this cycle.
// Assumes a nonzero SEED. With ENABLE = 0 it always allows completion.
module ahbmem_wait_gen #(
    parameter bit          ENABLE = 1'b1,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    output logic go_o
);

    if (ENABLE) begin : g_lfsr
        logic [15:0] lfsr;
        logic        fb;

        // Feedback tap combination.
        assign fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

        // Advance the sequence every cycle so stalls differ per transfer.
        always_ff @(posedge clk) begin
            if (!rst_n) lfsr <= SEED;
            else        lfsr <= {lfsr[14:0], fb};
        end

        assign go_o = lfsr[0];

        // R7: a stuck-at-zero LFSR would stall forever.
        a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
            lfsr != 16'h0000);
    end else begin : g_nowait
        assign go_o = 1'b1;
    end

endmodule

// File: rtl/ahbmem_lanes.sv
// Lane mask builder: marks the byte lanes covered by an access starting at
// lane off_i with 2**size_i bytes. Sizes wider than the bus cover all lanes.
// Assumes LANES is a power of two and at least 2.
module ahbmem_lanes #(
    parameter  int unsigned LANES = 4,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [2:0]       size_i,
    output logic [LANES-1:0] mask_o
);

    logic [OFF_W:0] span;
    logic [OFF_W:0] stop;

    // Byte count of the access and the first lane past it.
    always_comb begin
        if (size_i >= 3'(OFF_W)) span = (OFF_W+1)'(LANES);
        else                     span = (OFF_W+1)'(1) << size_i;
        stop = {1'b0, off_i} + span;
    end

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        assign mask_o[L] = ((OFF_W+1)'(L) >= {1'b0, off_i}) &&
                           ((OFF_W+1)'(L) < stop);
    end

    // R4: the starting lane is always part of the access.
    always_comb begin
        a_r4_first_lane: assert (mask_o[off_i]);
    end

endmodule

// File: rtl/ahbmem_store.sv
// Word-organised RAM with per-byte write enables and an asynchronous read
// of the addressed word. No reset: contents are undefined after power-up.
module ahbmem_store #(
    parameter  int unsigned DATA_W = 32,
    parameter  int unsigned WORDS  = 64,
    localparam int unsigned LANES  = DATA_W / 8,
    localparam int unsigned IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rword_o
);

    logic [DATA_W-1:0] mem [WORDS];

    // Commit enabled byte lanes of the addressed word.
    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int L = 0; L < int'(LANES); L++) begin
                if (be_i[L]) mem[idx_i][8*L +: 8] <= wdata_i[8*L +: 8];
            end
        end
    end

    assign rword_o = mem[idx_i];

endmodule

// File: rtl/ahbmem_sub.sv
// Bus-attached byte memory. Captures the address phase when ready_i is high,
// completes the access in the data phase, stretches data phases with
// LFSR-driven wait states and records bus ready during its own stall.
// Assumes BASE is aligned to the bus width and MEM_BYTES is a power-of-two
// multiple of it; never answers with an error response.
module ahbmem_sub
    import ahbmem_pkg::*;
#(
    parameter  int unsigned       ADDR_W    = 16,
    parameter  int unsigned       DATA_W    = 32,
    parameter  logic [ADDR_W-1:0] BASE      = 16'h1000,
    parameter  int unsigned       MEM_BYTES = 256,
    parameter  bit                WAITS_EN  = 1'b1,
    parameter  logic [15:0]       LFSR_SEED = 16'hACE1,
    localparam int unsigned       LANES     = DATA_W / 8,
    localparam int unsigned       LANE_W    = $clog2(LANES),
    localparam int unsigned       WORDS     = MEM_BYTES / LANES,
    localparam int unsigned       IDX_W     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              ready_i,
    input  logic [1:0]        trans_i,
    input  logic              write_i,
    input  logic [2:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              readyout_o,
    output logic              resp_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              proto_err_o
);

    localparam logic [ADDR_W:0] WIN_LO = {1'b0, BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(MEM_BYTES);

    logic              in_win;
    logic              active;
    logic              take;
    dctl_t             dctl;
    logic [LANE_W-1:0] d_off;
    logic [IDX_W-1:0]  d_idx;
    logic              go;
    logic [LANES-1:0]  mask;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] bitmask;
    logic              err_q;

    // Address-phase qualification: window hit and a real transfer type.
    always_comb begin
        in_win = ({1'b0, addr_i} >= WIN_LO) && ({1'b0, addr_i} < WIN_HI);
        active = (xfer_t'(trans_i) == XFER_NONSEQ) || (xfer_t'(trans_i) == XFER_SEQ);
        take   = sel_i && active && in_win;
    end

    // Latch the address phase whenever the bus moves on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dctl  <= '0;
            d_off <= '0;
            d_idx <= '0;
        end else if (ready_i) begin
            dctl.valid <= take;
            dctl.write <= write_i;
            dctl.size  <= size_i;
            d_off      <= addr_i[LANE_W-1:0];
            d_idx      <= IDX_W'((addr_i - BASE) >> LANE_W);
        end
    end

    ahbmem_wait_gen #(
        .ENABLE (WAITS_EN),
        .SEED   (LFSR_SEED)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .go_o  (go)
    );

    ahbmem_lanes #(
        .LANES (LANES)
    ) u_lanes (
        .off_i  (d_off),
        .size_i (dctl.size),
        .mask_o (mask)
    );

    ahbmem_store #(
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_store (
        .clk     (clk),
        .we_i    (dctl.valid && dctl.write && go),
        .idx_i   (d_idx),
        .be_i    (mask),
        .wdata_i (wdata_i),
        .rword_o (rword)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_bits
        assign bitmask[8*L +: 8] = {8{mask[L]}};
    end

    // Ready: stall only a taken transfer, and only when the LFSR says so.
    assign readyout_o = dctl.valid ? go : 1'b1;
    assign resp_o     = 1'b0;

    // Read data lives on covered lanes of a read data phase only.
    assign rdata_o = (dctl.valid && !dctl.write) ? (rword & bitmask) : '0;

    // Sticky record of the bus finishing a phase this block was holding.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err_q <= 1'b0;
        else if (ready_i && !readyout_o) err_q <= 1'b1;
    end

    assign proto_err_o = err_q;

    a_r2_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !(sel_i && active)) |=> readyout_o);

    a_r5_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && (!sel_i || write_i || !active)) |=> (rdata_o == '0));

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dctl.valid && !readyout_o && !ready_i) |=> $stable(dctl));

    a_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !readyout_o) |=> proto_err_o);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);

endmodule

// File: tb/sim_ahbmem_sub.sv
`timescale 1ns/1ps
module sim_ahbmem_sub;

    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned DATA_W    = 32;
    localparam logic [15:0] BASE      = 16'h1000;
    localparam int unsigned MEM_BYTES = 256;

    typedef struct packed {
        logic        w;
        logic [2:0]  sz;
        logic [15:0] a;
        logic [31:0] d;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd2, 16'h1000, 32'h11223344},
        '{1'b1, 3'd2, 16'h1004, 32'h01020304},
        '{1'b0, 3'd2, 16'h1000, 32'h0},
        '{1'b1, 3'd0, 16'h1001, 32'h0000AA00},
        '{1'b0, 3'd2, 16'h1000, 32'h0},
        '{1'b1, 3'd1, 16'h1006, 32'hBEEF0000},
        '{1'b0, 3'd1, 16'h1006, 32'h0},
        '{1'b0, 3'd2, 16'h1004, 32'h0},
        '{1'b0, 3'd0, 16'h1003, 32'h0},
        '{1'b1, 3'd2, 16'h10FC, 32'hCAFEF00D},
        '{1'b0, 3'd2, 16'h10FC, 32'h0},
        '{1'b1, 3'd2, 16'h1100, 32'hDEADDEAD},
        '{1'b1, 3'd2, 16'h0FFC, 32'h55555555},
        '{1'b0, 3'd2, 16'h1000, 32'h0},
        '{1'b0, 3'd2, 16'h1100, 32'h0},
        '{1'b1, 3'd0, 16'h10FE, 32'h00770000},
        '{1'b0, 3'd2, 16'h10FC, 32'h0},
        '{1'b0, 3'd1, 16'h10FC, 32'h0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_i = 1'b0;
    logic [1:0]        trans_i = 2'd0;
    logic              write_i = 1'b0;
    logic [2:0]        size_i = 3'd0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic              inject = 1'b0;
    logic              bus_ready;
    logic              readyout_o;
    logic              resp_o;
    logic [DATA_W-1:0] rdata_o;
    logic              proto_err_o;

    int   n_vec = 0;
    int   n_bad = 0;
    int   wait_cycles = 0;
    logic [7:0] model [MEM_BYTES];

    always #10 clk = ~clk;

    assign bus_ready = inject | readyout_o;

    ahbmem_sub u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_i),
        .ready_i     (bus_ready),
        .trans_i     (trans_i),
        .write_i     (write_i),
        .size_i      (size_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .readyout_o  (readyout_o),
        .resp_o      (resp_o),
        .rdata_o     (rdata_o),
        .proto_err_o (proto_err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_window(input logic [15:0] a);
        return (a >= BASE) && (32'(a) < 32'(BASE) + MEM_BYTES);
    endfunction

    function automatic int span_of(input logic [2:0] sz);
        return (sz >= 3'd2) ? 4 : (1 << sz);
    endfunction

    function automatic logic [31:0] expect_read(input logic [2:0] sz, input logic [15:0] a);
        logic [31:0] r = '0;
        int base_idx;
        int off;
        if (!in_window(a)) return '0;
        off = int'(a[1:0]);
        base_idx = int'(a - BASE) & ~3;
        for (int i = 0; i < span_of(sz); i++) begin
            if (off + i < 4) r[8*(off+i) +: 8] = model[base_idx + off + i];
        end
        return r;
    endfunction

    task automatic model_write(input logic [2:0] sz, input logic [15:0] a, input logic [31:0] d);
        int base_idx;
        int off;
        if (!in_window(a)) return;
        off = int'(a[1:0]);
        base_idx = int'(a - BASE) & ~3;
        for (int i = 0; i < span_of(sz); i++) begin
            if (off + i < 4) model[base_idx + off + i] = d[8*(off+i) +: 8];
        end
    endtask

    // One isolated transfer; inverted write data is driven during stalls (R9).
    task automatic xfer(input logic w, input logic [2:0] sz, input logic [15:0] a,
                        input logic [31:0] d, input string req);
        @(negedge clk);
        sel_i = 1'b1; trans_i = 2'd2; write_i = w; size_i = sz; addr_i = a; wdata_i = '0;
        @(negedge clk);
        sel_i = 1'b0; trans_i = 2'd0;
        while (readyout_o !== 1'b1) begin
            wait_cycles++;
            wdata_i = ~d;
            @(negedge clk);
        end
        wdata_i = d;
        if (!w) check(req, rdata_o, expect_read(sz, a));
        check("R6", 32'(resp_o), 32'd0);
        if (w) model_write(sz, a, d);
        @(posedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        bit found;
        for (int i = 0; i < int'(MEM_BYTES); i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset.
        check("R1", 32'(readyout_o), 32'd1);
        check("R1", 32'(proto_err_o), 32'd0);
        check("R1", rdata_o, 32'd0);

        // Vector table: lane writes and reads, window edges (R3, R4, R5, R9).
        for (int v = 0; v < NV; v++) begin
            xfer(VECS[v].w, VECS[v].sz, VECS[v].a, VECS[v].d,
                 in_window(VECS[v].a) ? "R4/R5" : "R3");
        end

        // R7: at least one stall must have occurred across the table.
        check("R7", 32'(wait_cycles > 0), 32'd1);

        // R2: busy and idle slots with select high neither stall nor write.
        @(negedge clk);
        sel_i = 1'b1; trans_i = 2'd1; write_i = 1'b1; size_i = 3'd2;
        addr_i = 16'h1000; wdata_i = 32'hFFFFFFFF;
        @(negedge clk);
        check("R2", 32'(readyout_o), 32'd1);
        check("R2", rdata_o, 32'd0);
        trans_i = 2'd0; write_i = 1'b0;
        @(negedge clk);
        check("R2", 32'(readyout_o), 32'd1);
        check("R2", rdata_o, 32'd0);
        sel_i = 1'b0; wdata_i = '0;
        xfer(1'b0, 3'd2, 16'h1000, 32'h0, "R2");

        // R10: write then read of one word presented back to back.
        @(negedge clk);
        sel_i = 1'b1; trans_i = 2'd2; write_i = 1'b1; size_i = 3'd2; addr_i = 16'h1008;
        @(negedge clk);
        write_i = 1'b0;
        while (readyout_o !== 1'b1) begin
            wait_cycles++;
            wdata_i = 32'h0BADF00D;
            @(negedge clk);
        end
        wdata_i = 32'h600DCAFE;
        model_write(3'd2, 16'h1008, 32'h600DCAFE);
        @(negedge clk);
        sel_i = 1'b0; trans_i = 2'd0;
        while (readyout_o !== 1'b1) @(negedge clk);
        check("R10", rdata_o, 32'h600DCAFE);
        @(posedge clk);

        // R8: no false flag from legal traffic, then force ready during a stall.
        @(negedge clk);
        check("R8", 32'(proto_err_o), 32'd0);
        found = 1'b0;
        for (int t = 0; t < 64 && !found; t++) begin
            @(negedge clk);
            sel_i = 1'b1; trans_i = 2'd2; write_i = 1'b0; size_i = 3'd2; addr_i = 16'h1000;
            @(negedge clk);
            sel_i = 1'b0; trans_i = 2'd0;
            if (readyout_o === 1'b0) begin
                inject = 1'b1;
                found = 1'b1;
                @(negedge clk);
                inject = 1'b0;
            end else begin
                @(posedge clk);
            end
        end
        check("R8", 32'(found), 32'd1);
        check("R8", 32'(proto_err_o), 32'd1);
        xfer(1'b0, 3'd2, 16'h1004, 32'h0, "R5");
        @(negedge clk);
        check("R8", 32'(proto_err_o), 32'd1);

        // R1: reset clears the flag and the data phase.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(proto_err_o), 32'd0);
        check("R1", 32'(readyout_o), 32'd1);
        check("R1", rdata_o, 32'd0);

        summary();
        $finish;
    end

endmodule